// File: doc/BRIEF.md
# Delayed One-Shot Pulse Timer

A 16-bit down-counting timer channel. It waits for a programmable delay and then emits one output pulse of programmable width. After that it halts. Software loads a start count and a reload value while the channel is idle. Software may also preset the idle level of the output flip-flop. Counting is then started either by writing the enable bit or by a one-cycle strobe from elsewhere, such as another timer's underflow. The counter moves only in cycles where the prescaler's count tick is high.

The channel runs two count phases. In the delay phase it counts down from the start count. When the counter underflows, the output level flips, an interrupt pulse is raised, and the reload value is loaded. The width phase then counts down from the reload value. When it underflows, the level flips back, a second interrupt is raised, and the channel stops. The rules for events that land in the same clock cycle are fixed, and so is the value the counter read-back shows in the cycle after a reload.

Top module: `dss_timer`

## Requirements
- R1: After a synchronous reset, `pulse_out` and `irq` are low, `cnt_rd` reads 0, the reload value is 0 and the channel is idle.
- R2: While idle, a cycle with `en_wr` high and `en_val` = 1 starts counting, and so does an `ext_trig` strobe. While counting, each cycle with `tick` high decrements the counter by one. A cycle with `tick` low leaves it unchanged.
- R3: An underflow is a tick taken while the counter is 16'h0000. The first underflow comes on the (C+1)-th tick after start, where C is the start count. It inverts `pulse_out` and loads the reload value R into the counter.
- R4: The second underflow comes on the (R+1)-th tick after the first. It inverts `pulse_out` back to its idle level and stops counting. The counter is then left at 16'hFFFF, and further ticks change neither the counter nor `pulse_out`.
- R5: `irq` is high for exactly one cycle after each underflow edge. A complete shot gives two such pulses, and `irq` is never high at any other time.
- R6: In the one cycle after the first-underflow reload, `cnt_rd` reads 16'hFFFF. From the next cycle it shows the loaded value minus the ticks taken since. So with `tick` held high it reads R−1.
- R7: If an `ext_trig` strobe falls in the same cycle as the second underflow, the stop wins and the channel halts.
- R8: If an enable write (`en_val` = 1) falls in the same cycle as the second underflow, the enable wins. Counting continues in the delay phase from 16'hFFFF.
- R9: If an `ext_trig` strobe falls in the same cycle as a disable write (`en_val` = 0), the disable wins and the channel stays idle.
- R10: A disable write stops counting at once and keeps both the counter and `pulse_out`. A later enable resumes from the held count.
- R11: `cnt_wr` and `lvl_wr` take effect in the next cycle only while the channel is idle, and are ignored while counting. `rld_wr` is accepted at any time. `lvl_wdata` sets the level of `pulse_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable from the prescaler |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Enable bit value written with `en_wr` |
| ext_trig | input | 1 | External start strobe |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 16 | Reload register write data |
| lvl_wr | input | 1 | Output level preset strobe |
| lvl_wdata | input | 1 | Output level preset value |
| pulse_out | output | 1 | Output flip-flop level |
| irq | output | 1 | One-cycle interrupt pulse per underflow |
| cnt_rd | output | 16 | Counter read-back value |

## Verification
The hardest cases to reach are the same-cycle collisions between the self-stop and a start or disable request. The stimulus for each has to land on the exact edge of the second underflow. The bench sets the start count and reload value to zero and holds `tick` high, so both underflows fall on the first two clock edges after the start. It then drives the competing strobe on the second edge. Which request won is read from the port: `cnt_rd` either keeps decrementing from 16'hFFFF or stays frozen.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic {
    PH_DELAY = 1'b0,
    PH_WIDTH = 1'b1
  } phase_e;
endpackage

// File: rtl/dss_ctrl.sv
// Run flag and phase tracking with the fixed same-cycle priority rules.
module dss_ctrl
  import dss_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en_wr,
  input  logic   en_val,
  input  logic   ext_trig,
  input  logic   uf,
  output logic   run,
  output phase_e phase,
  output logic   stop
);
  logic run_nxt;

  always_comb begin
    stop    = uf && (phase == PH_WIDTH);
    run_nxt = run;
    // self-stop beats the external strobe
    if (stop)          run_nxt = 1'b0;
    else if (ext_trig) run_nxt = 1'b1;
    // a write to the enable bit beats both
    if (en_wr)         run_nxt = en_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      phase <= PH_DELAY;
    end else begin
      run <= run_nxt;
      if (uf) phase <= (phase == PH_DELAY) ? PH_WIDTH : PH_DELAY;
    end
  end
endmodule

// File: rtl/dss_count.sv
// Down counter, reload register and read-back masking.
module dss_count
  import dss_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_act,
  input  phase_e       phase,
  input  logic         cnt_ok,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rld_wr,
  input  logic [W-1:0] rld_wdata,
  output logic         uf,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_rd
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] rld_q;
  logic         mask_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf      = tick_act && at_zero;

  always_ff @(posedge clk) begin
    if (rst) rld_q <= '0;
    else if (rld_wr) rld_q <= rld_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      mask_q <= uf && (phase == PH_DELAY);
      if (cnt_ok)
        cnt_q <= cnt_wdata;
      else if (tick_act)
        cnt_q <= (at_zero && phase == PH_DELAY) ? rld_q : cnt_q - ONE;
    end
  end

  assign cnt_rd = mask_q ? ALL_ONES : cnt_q;
endmodule

// File: rtl/dss_outff.sv
// Output flip-flop with preset level and interrupt pulse.
module dss_outff (
  input  logic clk,
  input  logic rst,
  input  logic lvl_ok,
  input  logic lvl_wdata,
  input  logic uf,
  output logic pulse_out,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= uf;
      if (lvl_ok)  pulse_out <= lvl_wdata;
      else if (uf) pulse_out <= ~pulse_out;
    end
  end
endmodule

// File: rtl/dss_timer.sv
module dss_timer
  import dss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             ext_trig,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] rld_wdata,
  input  logic             lvl_wr,
  input  logic             lvl_wdata,
  output logic             pulse_out,
  output logic             irq,
  output logic [CNT_W-1:0] cnt_rd
);
  logic             run_w;
  logic             stop_w;
  logic             uf_w;
  phase_e           phase_w;
  logic [CNT_W-1:0] cnt_q_w;

  dss_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en_wr   (en_wr),
    .en_val  (en_val),
    .ext_trig(ext_trig),
    .uf      (uf_w),
    .run     (run_w),
    .phase   (phase_w),
    .stop    (stop_w)
  );

  dss_count #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .tick_act (run_w && tick),
    .phase    (phase_w),
    .cnt_ok   (cnt_wr && !run_w),
    .cnt_wdata(cnt_wdata),
    .rld_wr   (rld_wr),
    .rld_wdata(rld_wdata),
    .uf       (uf_w),
    .cnt_q    (cnt_q_w),
    .cnt_rd   (cnt_rd)
  );

  dss_outff u_out (
    .clk      (clk),
    .rst      (rst),
    .lvl_ok   (lvl_wr && !run_w),
    .lvl_wdata(lvl_wdata),
    .uf       (uf_w),
    .pulse_out(pulse_out),
    .irq      (irq)
  );
endmodule

// File: rtl/dss_timer_chk.sv
module dss_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         en_wr,
  input logic         en_val,
  input logic         ext_trig,
  input logic         cnt_wr,
  input logic         lvl_wr,
  input logic         run,
  input logic         stop,
  input logic         irq,
  input logic         pulse_out,
  input logic [W-1:0] cnt_q
);
  // R9
  ext_vs_dis_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_trig && en_wr && !en_val) |=> !run);

  // R8
  en_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (en_wr && en_val) |=> run);

  // R7
  stop_beats_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (stop && ext_trig && !en_wr) |=> !run);

  // R5
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(tick) && $past(run)));

  // R3
  toggle_has_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((pulse_out != $past(pulse_out)) && !$past(lvl_wr)) |-> irq);

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(cnt_wr)) |-> $stable(cnt_q));
endmodule

bind dss_timer dss_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .en_wr    (en_wr),
  .en_val   (en_val),
  .ext_trig (ext_trig),
  .cnt_wr   (cnt_wr),
  .lvl_wr   (lvl_wr),
  .run      (run_w),
  .stop     (stop_w),
  .irq      (irq),
  .pulse_out(pulse_out),
  .cnt_q    (cnt_q_w)
);

// File: tb/dss_timer_tb.sv
module dss_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, en_wr = 1'b0, en_val = 1'b0, ext_trig = 1'b0;
  logic        cnt_wr = 1'b0, rld_wr = 1'b0, lvl_wr = 1'b0, lvl_wdata = 1'b0;
  logic [15:0] cnt_wdata = '0, rld_wdata = '0;
  logic        pulse_out, irq;
  logic [15:0] cnt_rd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dss_timer u_dut (
    .clk(clk), .rst(rst), .tick(tick), .en_wr(en_wr), .en_val(en_val),
    .ext_trig(ext_trig), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .rld_wr(rld_wr), .rld_wdata(rld_wdata), .lvl_wr(lvl_wr),
    .lvl_wdata(lvl_wdata), .pulse_out(pulse_out), .irq(irq), .cnt_rd(cnt_rd)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  // program start count, reload and idle level while stopped
  task automatic setup(logic [15:0] c, logic [15:0] r, logic lv);
    @(negedge clk);
    cnt_wr = 1; cnt_wdata = c; rld_wr = 1; rld_wdata = r; lvl_wr = 1; lvl_wdata = lv;
    @(negedge clk);
    cnt_wr = 0; rld_wr = 0; lvl_wr = 0;
  endtask

  task automatic start(bit use_ext);
    if (use_ext) ext_trig = 1; else begin en_wr = 1; en_val = 1; end
    @(negedge clk);
    ext_trig = 0; en_wr = 0;
  endtask

  task automatic stop_sw();
    en_wr = 1; en_val = 0;
    @(negedge clk);
    en_wr = 0;
  endtask

  // one tick cycle; returns at the negedge right after the tick edge
  task automatic one_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset_state();
    check("R1 pulse_out", pulse_out, 0);
    check("R1 irq", irq, 0);
    check("R1 cnt_rd", cnt_rd, 0);
    one_tick();
    check("R1 idle after tick", cnt_rd, 0);
  endtask

  // full shot with spaced ticks
  task automatic t_shot(logic [15:0] c, logic [15:0] r, bit use_ext, logic lv);
    int k = 0, t1 = -1, t2 = -1, nirq = 0;
    logic prev;
    do_reset();
    setup(c, r, lv);
    check("R11 level preset", pulse_out, lv);
    check("R11 count preset", cnt_rd, c);
    start(use_ext);
    prev = pulse_out;
    while (t2 < 0 && k < 200) begin
      one_tick();
      k++;
      if (irq) nirq++;
      if (pulse_out != prev) begin
        if (t1 < 0) begin
          t1 = k;
          check("R6 masked read after reload", cnt_rd, 16'hFFFF);
          @(negedge clk);
          check("R5 irq one cycle", irq, 0);
          check("R6 loaded value", cnt_rd, r);
        end else t2 = k;
        prev = pulse_out;
      end else if (k == 1) check("R2 first decrement", cnt_rd, c - 16'd1);
      @(negedge clk);
    end
    check("R3 delay ticks", t1, c + 1);
    check("R4 width ticks", t2 - t1, r + 1);
    check("R5 irq count", nirq, 2);
    check("R4 back to idle level", pulse_out, lv);
    check("R4 counter after stop", cnt_rd, 16'hFFFF);
    one_tick(); one_tick();
    check("R4 halted counter", cnt_rd, 16'hFFFF);
    check("R4 halted level", pulse_out, lv);
  endtask

  // tick held high through the reload
  task automatic t_cont_reload();
    do_reset();
    setup(16'd1, 16'd5, 1'b0);
    tick = 1; en_wr = 1; en_val = 1;
    @(negedge clk) en_wr = 0;            // after start edge
    @(negedge clk);                       // after 1 -> 0
    check("R2 count to zero", cnt_rd, 0);
    @(negedge clk);                       // after first underflow
    check("R5 irq at underflow", irq, 1);
    check("R6 masked read", cnt_rd, 16'hFFFF);
    @(negedge clk);
    check("R6 reload minus one", cnt_rd, 4);
    tick = 0;
    stop_sw();
  endtask

  // second underflow collides with a start request
  task automatic t_collide(bit use_ext);
    do_reset();
    setup(16'd0, 16'd0, 1'b0);
    tick = 1; en_wr = 1; en_val = 1;
    @(negedge clk) en_wr = 0;             // after start edge
    @(negedge clk);                       // after first underflow
    check("R3 first toggle", pulse_out, 1);
    if (use_ext) ext_trig = 1; else begin en_wr = 1; en_val = 1; end
    @(negedge clk);                       // after second underflow
    ext_trig = 0; en_wr = 0;
    check("R4 second toggle", pulse_out, 0);
    check("R4 wrap value", cnt_rd, 16'hFFFF);
    @(negedge clk);
    tick = 0;
    if (use_ext) check("R7 stop beats trigger", cnt_rd, 16'hFFFF);
    else check("R8 enable beats stop", cnt_rd, 16'hFFFE);
    stop_sw();
  endtask

  task automatic t_ext_vs_disable();
    do_reset();
    setup(16'd7, 16'd3, 1'b0);
    ext_trig = 1; en_wr = 1; en_val = 0;
    @(negedge clk);
    ext_trig = 0; en_wr = 0;
    one_tick(); one_tick(); one_tick();
    check("R9 disable beats trigger", cnt_rd, 7);
  endtask

  task automatic t_disable_resume();
    do_reset();
    setup(16'd4, 16'd2, 1'b1);
    start(1'b0);
    one_tick(); one_tick();
    check("R2 two ticks", cnt_rd, 2);
    cnt_wr = 1; cnt_wdata = 16'h0055; lvl_wr = 1; lvl_wdata = 1'b0;
    @(negedge clk);
    cnt_wr = 0; lvl_wr = 0;
    check("R11 count write ignored", cnt_rd, 2);
    check("R11 level write ignored", pulse_out, 1);
    stop_sw();
    one_tick(); one_tick(); one_tick();
    check("R10 count held", cnt_rd, 2);
    check("R10 level held", pulse_out, 1);
    start(1'b0);
    one_tick(); one_tick();
    check("R10 resumed count", cnt_rd, 0);
    one_tick();
    check("R10 toggle after resume", pulse_out, 0);
    stop_sw();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_shot(16'd3, 16'd2, 1'b0, 1'b0);
    t_shot(16'd0, 16'd0, 1'b1, 1'b0);
    t_shot(16'd5, 16'd1, 1'b0, 1'b1);
    t_shot(16'd1, 16'd4, 1'b1, 1'b1);
    t_cont_reload();
    t_collide(1'b0);
    t_collide(1'b1);
    t_ext_vs_disable();
    t_disable_resume();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule